// File: doc/BRIEF.md
# Audio LSB Watermark Embedder and Authenticator

This block carries a hidden 64-bit authentication matrix inside the least significant bit of a stream of 12-bit audio samples. On the transmit path, each valid sample leaves the block one cycle later. Its upper bits are unchanged, and bit 0 is replaced by the next bit of an already scrambled message word. The embedding restarts on a frame-start strobe and repeats every 64 samples.

On the receive path, the block removes the hidden bit from each valid sample and forwards the audio with bit 0 cleared. It aligns to the frame strobe and gathers 64 hidden bits into an 8x8 matrix, which it presents with a one-cycle valid pulse. An external descrambler, which is not part of this block, returns the unscrambled matrix. The block compares that matrix with a stored reference pattern and drives a single authentic/not-authentic flag, for example to an LED.

Top module: `lsb_watermark_auth`

## Requirements
- R1: A sample presented with `tx_valid` high appears one cycle later on `tx_out_sample`, with `tx_out_valid` high. Bits 11:1 of the output are equal to the input, and bit 0 is equal to `tx_msg[k]`, where k is the current embed index.
- R2: The embed index is 0 for a valid sample that has `tx_frame_start` high. Otherwise it is the previous valid sample's index plus one. After 63 the index wraps to 0, so the message repeats every 64 samples.
- R3: A cycle with `tx_valid` low gives `tx_out_valid` low one cycle later and leaves the embed index unchanged.
- R4: A sample presented with `rx_valid` high gives `rx_audio_valid` high one cycle later, with `rx_audio` equal to the sample with bit 0 forced to 0.
- R5: Before the first valid sample that has `rx_frame_start` high, received hidden bits are ignored and `rx_matrix_valid` stays low.
- R6: The hidden bit of the aligned received sample with index k (k = 8*row + col) is stored at `rx_matrix[k]`. One cycle after the sample with index 63, `rx_matrix_valid` pulses high for one cycle and `rx_matrix` updates in that same cycle. At all other times `rx_matrix` holds its value.
- R7: A valid sample that has `rx_frame_start` high in the middle of a collection discards the partial bits and becomes index 0 of a new collection.
- R8: One cycle after `desc_valid` is high, `auth_ok` is 1 when `desc_matrix` equals `REF_PATTERN`, and 0 otherwise.
- R9: While `desc_valid` is low, `auth_ok` holds its value.
- R10: While reset is asserted, `auth_ok`, `tx_out_valid`, `rx_audio_valid` and `rx_matrix_valid` are 0, `rx_matrix` is 0, and both bit indices are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_frame_start | input | 1 | Marks the valid transmit sample that carries message bit 0 |
| tx_valid | input | 1 | Transmit sample valid |
| tx_sample | input | 12 | Transmit audio sample |
| tx_msg | input | 64 | Scrambled message to embed |
| tx_out_valid | output | 1 | Watermarked sample valid |
| tx_out_sample | output | 12 | Watermarked audio sample |
| rx_frame_start | input | 1 | Marks the valid received sample that carries matrix bit 0 |
| rx_valid | input | 1 | Received sample valid |
| rx_sample | input | 12 | Received watermarked sample |
| rx_audio_valid | output | 1 | Recovered audio valid |
| rx_audio | output | 12 | Recovered audio with bit 0 cleared |
| rx_matrix_valid | output | 1 | One-cycle pulse when a 64-bit matrix is complete |
| rx_matrix | output | 64 | Collected scrambled matrix, sent to the descrambler |
| desc_valid | input | 1 | Descrambled matrix valid |
| desc_matrix | input | 64 | Descrambled matrix from the external descrambler |
| auth_ok | output | 1 | 1 = authentic, 0 = not authentic |

## Verification
The assertions assume that reset is asserted from time zero with every valid and strobe input held low. They also assume that `tx_msg` and `desc_matrix` are only relevant in cycles where their own qualifiers are high. The bench drives all inputs one time step after a rising edge and returns every valid and strobe to 0 between scenarios. A frame strobe is only ever raised together with its valid, which is the only combination the block interprets. Received samples take their hidden bit from a known matrix, so the collected result has a single expected value.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int unsigned SAMPLE_W_DEF = 12;
  localparam int unsigned MSG_ROWS_DEF = 8;
  localparam int unsigned MSG_COLS_DEF = 8;
  localparam logic [63:0] REF_DEF      = 64'hC3A5_5A3C_0FF0_9669;
endpackage

// File: rtl/wm_embedder.sv
module wm_embedder #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned MSG_BITS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [MSG_BITS-1:0] msg,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sample
);
  localparam int unsigned IDX_W = $clog2(MSG_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_BITS - 1);

  logic [IDX_W-1:0]    idx_q, idx_d, sel;
  logic [SAMPLE_W-1:0] samp_q, samp_d;
  logic                valid_q, valid_d;

  // Next-state logic: choose the message bit and advance the embed index.
  always_comb begin
    sel     = frame_start ? '0 : idx_q;
    idx_d   = idx_q;
    samp_d  = samp_q;
    valid_d = in_valid;
    if (in_valid) begin
      samp_d = {in_sample[SAMPLE_W-1:1], msg[sel]};
      idx_d  = (sel == LAST_IDX) ? '0 : sel + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      samp_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      samp_q  <= samp_d;
      valid_q <= valid_d;
    end
  end

  assign out_valid  = valid_q;
  assign out_sample = samp_q;
endmodule

// File: rtl/wm_extractor.sv
module wm_extractor #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned MSG_BITS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                audio_valid,
  output logic [SAMPLE_W-1:0] audio,
  output logic                matrix_valid,
  output logic [MSG_BITS-1:0] matrix
);
  localparam int unsigned IDX_W = $clog2(MSG_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_BITS - 1);

  logic [IDX_W-1:0]    idx_q, idx_d, sel;
  logic                aligned_q, aligned_d;
  logic [MSG_BITS-1:0] acc_q, acc_d, mat_q, mat_d;
  logic                mv_q, mv_d;
  logic [SAMPLE_W-1:0] aud_q, aud_d;
  logic                av_q, av_d;
  logic                take, last;

  // Next-state logic: frame alignment, bit collection, audio split.
  always_comb begin
    sel       = frame_start ? '0 : idx_q;
    take      = in_valid && (frame_start || aligned_q);
    last      = (sel == LAST_IDX);
    aligned_d = aligned_q | (in_valid & frame_start);
    acc_d     = acc_q;
    mat_d     = mat_q;
    mv_d      = 1'b0;
    idx_d     = idx_q;
    if (take) begin
      acc_d[sel] = in_sample[0];
      idx_d      = last ? '0 : sel + 1'b1;
      if (last) begin
        mat_d = acc_d;
        mv_d  = 1'b1;
      end
    end
    av_d  = in_valid;
    aud_d = in_valid ? {in_sample[SAMPLE_W-1:1], 1'b0} : aud_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      aligned_q <= 1'b0;
      acc_q     <= '0;
      mat_q     <= '0;
      mv_q      <= 1'b0;
      aud_q     <= '0;
      av_q      <= 1'b0;
    end else begin
      idx_q     <= idx_d;
      aligned_q <= aligned_d;
      acc_q     <= acc_d;
      mat_q     <= mat_d;
      mv_q      <= mv_d;
      aud_q     <= aud_d;
      av_q      <= av_d;
    end
  end

  assign audio_valid  = av_q;
  assign audio        = aud_q;
  assign matrix_valid = mv_q;
  assign matrix       = mat_q;
endmodule

// File: rtl/wm_comparator.sv
module wm_comparator #(
  parameter int unsigned       MSG_BITS    = 64,
  parameter logic [MSG_BITS-1:0] REF_PATTERN = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                desc_valid,
  input  logic [MSG_BITS-1:0] desc_matrix,
  output logic                auth_ok
);
  logic ok_q, ok_d;

  always_comb begin
    ok_d = ok_q;
    if (desc_valid) ok_d = (desc_matrix == REF_PATTERN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= ok_d;
  end

  assign auth_ok = ok_q;
endmodule

// File: rtl/lsb_watermark_auth.sv
module lsb_watermark_auth
  import wm_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned MSG_ROWS = MSG_ROWS_DEF,
  parameter int unsigned MSG_COLS = MSG_COLS_DEF,
  parameter logic [MSG_ROWS*MSG_COLS-1:0] REF_PATTERN = REF_DEF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tx_frame_start,
  input  logic                         tx_valid,
  input  logic [SAMPLE_W-1:0]          tx_sample,
  input  logic [MSG_ROWS*MSG_COLS-1:0] tx_msg,
  output logic                         tx_out_valid,
  output logic [SAMPLE_W-1:0]          tx_out_sample,
  input  logic                         rx_frame_start,
  input  logic                         rx_valid,
  input  logic [SAMPLE_W-1:0]          rx_sample,
  output logic                         rx_audio_valid,
  output logic [SAMPLE_W-1:0]          rx_audio,
  output logic                         rx_matrix_valid,
  output logic [MSG_ROWS*MSG_COLS-1:0] rx_matrix,
  input  logic                         desc_valid,
  input  logic [MSG_ROWS*MSG_COLS-1:0] desc_matrix,
  output logic                         auth_ok
);
  localparam int unsigned MSG_BITS = MSG_ROWS * MSG_COLS;

  wm_embedder #(.SAMPLE_W(SAMPLE_W), .MSG_BITS(MSG_BITS)) u_embed (
    .clk(clk), .rst_n(rst_n),
    .frame_start(tx_frame_start), .in_valid(tx_valid), .in_sample(tx_sample),
    .msg(tx_msg), .out_valid(tx_out_valid), .out_sample(tx_out_sample)
  );

  wm_extractor #(.SAMPLE_W(SAMPLE_W), .MSG_BITS(MSG_BITS)) u_extract (
    .clk(clk), .rst_n(rst_n),
    .frame_start(rx_frame_start), .in_valid(rx_valid), .in_sample(rx_sample),
    .audio_valid(rx_audio_valid), .audio(rx_audio),
    .matrix_valid(rx_matrix_valid), .matrix(rx_matrix)
  );

  wm_comparator #(.MSG_BITS(MSG_BITS), .REF_PATTERN(REF_PATTERN)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_matrix(desc_matrix), .auth_ok(auth_ok)
  );
endmodule

// File: rtl/lsb_watermark_auth_chk.sv
module lsb_watermark_auth_chk #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned MSG_BITS = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tx_valid,
  input logic [SAMPLE_W-1:0] tx_sample,
  input logic                tx_out_valid,
  input logic [SAMPLE_W-1:0] tx_out_sample,
  input logic                rx_valid,
  input logic [SAMPLE_W-1:0] rx_sample,
  input logic                rx_audio_valid,
  input logic [SAMPLE_W-1:0] rx_audio,
  input logic                rx_matrix_valid,
  input logic [MSG_BITS-1:0] rx_matrix,
  input logic                desc_valid,
  input logic                auth_ok
);
  p_tx_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> tx_out_valid && (tx_out_sample[SAMPLE_W-1:1] == $past(tx_sample[SAMPLE_W-1:1])));

  p_tx_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |=> !tx_out_valid);

  p_rx_audio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_audio_valid && (rx_audio == {$past(rx_sample[SAMPLE_W-1:1]), 1'b0}));

  p_matrix_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_matrix_valid |-> $stable(rx_matrix));

  p_matrix_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_matrix_valid |-> $past(rx_valid));

  p_auth_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !desc_valid |=> $stable(auth_ok));
endmodule

bind lsb_watermark_auth lsb_watermark_auth_chk #(
  .SAMPLE_W(SAMPLE_W), .MSG_BITS(MSG_ROWS*MSG_COLS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_valid(tx_valid), .tx_sample(tx_sample),
  .tx_out_valid(tx_out_valid), .tx_out_sample(tx_out_sample),
  .rx_valid(rx_valid), .rx_sample(rx_sample),
  .rx_audio_valid(rx_audio_valid), .rx_audio(rx_audio),
  .rx_matrix_valid(rx_matrix_valid), .rx_matrix(rx_matrix),
  .desc_valid(desc_valid), .auth_ok(auth_ok)
);

// File: tb/test_lsb_watermark_auth.sv
module test_lsb_watermark_auth;
  localparam logic [63:0] REF = 64'hC3A5_5A3C_0FF0_9669;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_frame_start, tx_valid;
  logic [11:0] tx_sample;
  logic [63:0] tx_msg;
  logic        tx_out_valid;
  logic [11:0] tx_out_sample;
  logic        rx_frame_start, rx_valid;
  logic [11:0] rx_sample;
  logic        rx_audio_valid;
  logic [11:0] rx_audio;
  logic        rx_matrix_valid;
  logic [63:0] rx_matrix;
  logic        desc_valid;
  logic [63:0] desc_matrix;
  logic        auth_ok;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  lsb_watermark_auth i_lsb_watermark_auth (
    .clk(clk), .rst_n(rst_n),
    .tx_frame_start(tx_frame_start), .tx_valid(tx_valid), .tx_sample(tx_sample),
    .tx_msg(tx_msg), .tx_out_valid(tx_out_valid), .tx_out_sample(tx_out_sample),
    .rx_frame_start(rx_frame_start), .rx_valid(rx_valid), .rx_sample(rx_sample),
    .rx_audio_valid(rx_audio_valid), .rx_audio(rx_audio),
    .rx_matrix_valid(rx_matrix_valid), .rx_matrix(rx_matrix),
    .desc_valid(desc_valid), .desc_matrix(desc_matrix), .auth_ok(auth_ok)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [11:0] pat(input int i);
    return 12'((i * 37 + 5) & 12'hFFF);
  endfunction

  task automatic idle_inputs();
    tx_frame_start = 0; tx_valid = 0; tx_sample = '0;
    rx_frame_start = 0; rx_valid = 0; rx_sample = '0;
    desc_valid = 0; desc_matrix = '0;
  endtask

  task automatic t_reset();
    idle_inputs();
    tx_msg = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 tx_out_valid", 64'(tx_out_valid), 0);
    check("R10 rx_audio_valid", 64'(rx_audio_valid), 0);
    check("R10 rx_matrix_valid", 64'(rx_matrix_valid), 0);
    check("R10 rx_matrix", rx_matrix, 0);
    check("R10 auth_ok", 64'(auth_ok), 0);
    rst_n = 1;
    step();
  endtask

  // R1, R2: embed over 70 samples with wrap past 63
  task automatic t_tx_embed();
    int errs = 0;
    tx_msg = 64'h8421_F00F_AA55_1337;
    for (int i = 0; i < 70; i++) begin
      tx_valid = 1; tx_frame_start = (i == 0); tx_sample = pat(i);
      step();
      if (!tx_out_valid || tx_out_sample !== {pat(i)[11:1], tx_msg[i % 64]}) begin
        errs++;
        $display("FAIL R1/R2 sample %0d: got %h expected %h", i, tx_out_sample,
                 {pat(i)[11:1], tx_msg[i % 64]});
      end
    end
    n_checks++; if (errs != 0) n_fail++;
    tx_valid = 0; tx_frame_start = 0;
    step();
  endtask

  // R3 idle cycles keep index; R2 frame start mid-frame restarts
  task automatic t_tx_gap();
    tx_msg = 64'h0000_0000_0000_0006;  // bit1=1, bit2=1, bit0=0, bit3=0
    tx_valid = 1; tx_frame_start = 1; tx_sample = 12'hFFF;
    step();
    check("R1 bit0", 64'(tx_out_sample), 64'hFFE);
    tx_valid = 0; tx_frame_start = 0;
    step();
    check("R3 idle valid", 64'(tx_out_valid), 0);
    step();
    tx_valid = 1; tx_sample = 12'h800;
    step();
    check("R3 index held (bit1)", 64'(tx_out_sample), 64'h801);
    tx_frame_start = 1; tx_sample = 12'h000;
    step();
    check("R2 restart to bit0", 64'(tx_out_sample), 64'h000);
    tx_frame_start = 0;
    step();
    check("R2 after restart bit1", 64'(tx_out_sample), 64'h001);
    tx_valid = 0;
    step();
  endtask

  // R4 audio path, R5 no alignment before frame start
  task automatic t_rx_unaligned();
    int mv_seen = 0;
    int aerr = 0;
    for (int i = 0; i < 70; i++) begin
      rx_valid = 1; rx_sample = pat(i) | 12'h001;
      step();
      if (rx_matrix_valid) mv_seen++;
      if (!rx_audio_valid || rx_audio !== {pat(i)[11:1], 1'b0}) aerr++;
    end
    rx_valid = 0;
    step();
    if (rx_matrix_valid) mv_seen++;
    check("R5 no matrix before align", 64'(mv_seen), 0);
    check("R5 matrix untouched", rx_matrix, 0);
    check("R4 audio errors", 64'(aerr), 0);
    check("R4 audio valid drops", 64'(rx_audio_valid), 0);
  endtask

  task automatic rx_frame(input logic [63:0] m, input bit expect_done);
    int early = 0;
    for (int k = 0; k < 64; k++) begin
      rx_valid = 1; rx_frame_start = (k == 0);
      rx_sample = {pat(k)[11:1], m[k]};
      step();
      if (k < 63 && rx_matrix_valid) early++;
    end
    rx_valid = 0; rx_frame_start = 0;
    check("R6 no early matrix_valid", 64'(early), 0);
    if (expect_done) begin
      check("R6 matrix_valid pulse", 64'(rx_matrix_valid), 1);
      check("R6 matrix content", rx_matrix, m);
    end
  endtask

  task automatic t_rx_collect();
    rx_frame(64'hDEAD_BEEF_0123_4567, 1);
    step();
    check("R6 pulse one cycle", 64'(rx_matrix_valid), 0);
    check("R6 matrix holds", rx_matrix, 64'hDEAD_BEEF_0123_4567);
  endtask

  // R7 restart mid-collection
  task automatic t_rx_restart();
    int early = 0;
    for (int k = 0; k < 20; k++) begin
      rx_valid = 1; rx_frame_start = (k == 0); rx_sample = 12'h001;
      step();
      if (rx_matrix_valid) early++;
    end
    check("R7 no pulse on partial", 64'(early), 0);
    rx_frame(64'h1357_9BDF_2468_ACE0, 1);
    check("R7 restarted matrix", rx_matrix, 64'h1357_9BDF_2468_ACE0);
    step();
  endtask

  task automatic t_auth();
    desc_valid = 1; desc_matrix = REF;
    step();
    check("R8 match", 64'(auth_ok), 1);
    desc_valid = 0; desc_matrix = ~REF;
    step(); step();
    check("R9 hold authentic", 64'(auth_ok), 1);
    desc_valid = 1; desc_matrix = REF ^ 64'h1;
    step();
    check("R8 single-bit mismatch", 64'(auth_ok), 0);
    desc_valid = 0; desc_matrix = REF;
    step(); step();
    check("R9 hold not-authentic", 64'(auth_ok), 0);
  endtask

  initial begin
    t_reset();
    t_tx_embed();
    t_tx_gap();
    t_rx_unaligned();
    t_rx_collect();
    t_rx_restart();
    t_auth();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule